// File: doc/BRIEF.md
# March Test Engine for Word-Wide RAM

This block is a built-in self-test sequencer that drives a synchronous single-port RAM through a march algorithm. A march algorithm is a short list of elements. Each element walks the whole address space in a fixed direction, either up or down. At every address the element applies its read and write operations before it moves on to the next address. The engine carries two programs. The default is a three-element test whose last element ends with a verifying read. The alternative is a shorter variant that drops that final read.

The RAM is word-wide, so the engine does not write all-zero and all-one words. It uses a background word B and its bitwise complement ~B in their place. B is sampled together with the program select when a test is started. Every read returns a full word, and the engine compares that word with the value the current operation expects. The first mismatch sets a sticky fail flag and records the address and element index where it happened. A single-cycle `done` pulse ends the run.

Top module: `march_bist`

## Requirements
- R1: A `start` pulse while idle samples `alg_sel` (0 = long program, 1 = short program) and `bg_word`, clears the fail record and raises `busy` in the next cycle. Later changes to `alg_sel` or `bg_word` do not affect the run.
- R2: While running, the engine issues exactly one memory operation per cycle. The long program issues 6·N operations in total and the short program 5·N, where N = 2^ADDR_W.
- R3: The element order is: element 0 ascending {write B}; element 1 ascending {read B, write ~B}; element 2 descending {read ~B, write B, read B}. In the short program, element 2 omits its final read B.
- R4: An ascending element visits addresses 0 to N-1 and a descending element visits N-1 down to 0. All operations of an element complete at one address before the address changes.
- R5: A write drives `mem_we`=1 with `mem_wdata` equal to B or ~B as R3 specifies. A read drives `mem_we`=0.
- R6: Read data is taken from `mem_rdata` one cycle after the read is issued. The engine compares all DATA_W bits against the expected word.
- R7: The first mismatching read sets `fail` and latches its address in `fail_addr` and its element index (0, 1 or 2) in `fail_elem`. Later mismatches leave all three unchanged until the next accepted start. A run with no mismatch ends with `fail`=0.
- R8: `done` is high for exactly one cycle, two cycles after the last operation is issued. In that cycle `busy` is low and the fail record is final.
- R9: A `start` pulse while `busy` is high is ignored. The operation stream and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a test when idle |
| alg_sel | input | 1 | Program select: 0 long, 1 short |
| bg_word | input | DATA_W | Background word B |
| mem_en | output | 1 | Memory operation valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 2 | Element index of the first mismatch |

## Verification
The assertions take for granted that the attached RAM answers every read with data exactly one cycle later and never stalls. They also assume that `start` is a clean single-cycle pulse, so the fail record changes only at an accepted start or at a mismatch.

The bench meets these assumptions with a zero-wait RAM model that has one-cycle read latency. It injects stuck bits only through that model's write path, and it pulses `start` for one cycle, including the one deliberate pulse that arrives while a run is in progress.

// File: rtl/march_pkg.sv
// Package: operation codes and the element table shared by the march engine.
// Assumes exactly three elements in both programs; element 2 is the only descending one.
package march_pkg;

    localparam int NUM_ELEMS = 3;
    localparam int ELEM_W    = 2;

    // bit1 = read, bit0 = use complement of the background
    typedef enum logic [1:0] {
        OP_WR_BG = 2'b00,
        OP_WR_CP = 2'b01,
        OP_RD_BG = 2'b10,
        OP_RD_CP = 2'b11
    } march_op_t;

    typedef struct packed {
        logic      down;
        logic [1:0] nops;
        march_op_t op0;
        march_op_t op1;
        march_op_t op2;
    } march_elem_t;

    // Direction of an element (only the last one descends)
    function automatic logic elem_down(input logic [ELEM_W-1:0] idx);
        return idx == ELEM_W'(NUM_ELEMS - 1);
    endfunction

    // Element description for the selected program
    function automatic march_elem_t elem_table(input logic alg_short,
                                               input logic [ELEM_W-1:0] idx);
        march_elem_t e;
        e.down = elem_down(idx);
        case (idx)
            2'd1: begin
                e.nops = 2'd2;
                e.op0 = OP_RD_BG; e.op1 = OP_WR_CP; e.op2 = OP_WR_CP;
            end
            2'd2: begin
                e.nops = alg_short ? 2'd2 : 2'd3;
                e.op0 = OP_RD_CP; e.op1 = OP_WR_BG; e.op2 = OP_RD_BG;
            end
            default: begin
                e.nops = 2'd1;
                e.op0 = OP_WR_BG; e.op1 = OP_WR_BG; e.op2 = OP_WR_BG;
            end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/march_prog.sv
// Program decoder: turns (program, element, operation slot) into the operation to
// issue, the element direction and a flag for the element's last operation.
// Assumes op_idx never exceeds the element's operation count minus one.
module march_prog
    import march_pkg::*;
(
    input  logic              alg_short,
    input  logic [ELEM_W-1:0] elem_idx,
    input  logic [1:0]        op_idx,
    output march_op_t         op,
    output logic              op_last,
    output logic              dir_down
);

    march_elem_t cfg;

    // Look up the element and pick the operation slot
    always_comb begin
        cfg      = elem_table(alg_short, elem_idx);
        dir_down = cfg.down;
        op_last  = (op_idx == cfg.nops - 2'd1);
        case (op_idx)
            2'd0:    op = cfg.op0;
            2'd1:    op = cfg.op1;
            default: op = cfg.op2;
        endcase
    end

endmodule

// File: rtl/march_cmp.sv
// Read checker: registers each issued read's expectation, compares it with the
// memory word one cycle later and keeps the first mismatch.
// Assumes the memory returns read data exactly one cycle after the read.
module march_cmp
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              issue_rd,
    input  logic [DATA_W-1:0] issue_exp,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [ELEM_W-1:0] issue_elem,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem
);

    logic              pend_v;
    logic [DATA_W-1:0] pend_exp;
    logic [ADDR_W-1:0] pend_addr;
    logic [ELEM_W-1:0] pend_elem;
    logic              mismatch;

    // Pipeline the expectation to line up with the returned word
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend_v    <= 1'b0;
            pend_exp  <= '0;
            pend_addr <= '0;
            pend_elem <= '0;
        end else begin
            pend_v    <= issue_rd;
            pend_exp  <= issue_exp;
            pend_addr <= issue_addr;
            pend_elem <= issue_elem;
        end
    end

    // Full-word comparison of the returned data
    assign mismatch = pend_v && (rdata != pend_exp);

    // Sticky record of the first failing read
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
        end else if (mismatch && !fail) begin
            fail      <= 1'b1;
            fail_addr <= pend_addr;
            fail_elem <= pend_elem;
        end
    end

endmodule

// File: rtl/march_bist.sv
// March test engine top: walks elements, addresses and operations, one memory
// operation per cycle, then waits for the final read to be checked.
// Assumes a single-port synchronous RAM with one-cycle read latency and no stalls.
module march_bist
    import march_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              alg_sel,
    input  logic [DATA_W-1:0] bg_word,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [1:0]        fail_elem
);

    localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
    localparam logic [ELEM_W-1:0] ELEM_LAST = ELEM_W'(NUM_ELEMS - 1);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

    state_t            state;
    logic              alg_q;
    logic [DATA_W-1:0] bg_q;
    logic [ELEM_W-1:0] elem_q;
    logic [1:0]        opi_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;

    march_op_t         cur_op;
    logic              op_last;
    logic              cur_down;
    logic              addr_end;
    logic              start_ok;
    logic [ELEM_W-1:0] elem_nxt;
    logic [DATA_W-1:0] op_data;

    march_prog u_prog (
        .alg_short (alg_q),
        .elem_idx  (elem_q),
        .op_idx    (opi_q),
        .op        (cur_op),
        .op_last   (op_last),
        .dir_down  (cur_down)
    );

    // Address and element boundary decode
    always_comb begin
        start_ok = start && (state == S_IDLE);
        addr_end = cur_down ? (addr_q == '0) : (addr_q == ADDR_LAST);
        elem_nxt = elem_q + 1'b1;
        op_data  = cur_op[0] ? ~bg_q : bg_q;
    end

    // Sequencer: element, address and operation counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            alg_q  <= 1'b0;
            bg_q   <= '0;
            elem_q <= '0;
            opi_q  <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state  <= S_RUN;
                        alg_q  <= alg_sel;
                        bg_q   <= bg_word;
                        elem_q <= '0;
                        opi_q  <= '0;
                        addr_q <= elem_down('0) ? ADDR_LAST : '0;
                    end
                end
                S_RUN: begin
                    if (!op_last) begin
                        opi_q <= opi_q + 2'd1;
                    end else begin
                        opi_q <= '0;
                        if (!addr_end) begin
                            addr_q <= cur_down ? addr_q - 1'b1 : addr_q + 1'b1;
                        end else if (elem_q == ELEM_LAST) begin
                            state <= S_FIN;
                        end else begin
                            elem_q <= elem_nxt;
                            addr_q <= elem_down(elem_nxt) ? ADDR_LAST : '0;
                        end
                    end
                end
                default: begin
                    state  <= S_IDLE;
                    done_q <= 1'b1;
                end
            endcase
        end
    end

    march_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start_ok),
        .issue_rd   (mem_en && cur_op[1]),
        .issue_exp  (op_data),
        .issue_addr (addr_q),
        .issue_elem (elem_q),
        .rdata      (mem_rdata),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .fail_elem  (fail_elem)
    );

    // Memory port and status outputs
    always_comb begin
        mem_en    = (state == S_RUN);
        mem_we    = mem_en && !cur_op[1];
        mem_addr  = addr_q;
        mem_wdata = op_data;
        busy      = (state != S_IDLE);
        done      = done_q;
    end

endmodule

// File: rtl/march_bist_chk.sv
// Checker for the march engine: protocol and result-record properties.
// Assumes one-cycle read latency and single-cycle start pulses.
module march_bist_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [1:0]        fail_elem,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);

    logic              prev_en;
    logic [ADDR_W-1:0] prev_addr;
    logic [ADDR_W-1:0] step;

    // Remember the previous issued address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_en   <= mem_en;
            prev_addr <= mem_addr;
        end
    end

    // Address step between consecutive operations
    assign step = mem_addr - prev_addr;

    // R1
    start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && prev_en) |-> (step == '0 || step == ADDR_W'(1) || step == '1));

    // R5
    we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

    // R2
    en_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R7
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(start && !busy)) |=> (fail && $stable(fail_addr) && $stable(fail_elem)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind march_bist march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/march_bist_bench.sv
module march_bist_bench;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;
    localparam int MAXOPS = 6 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          alg_sel = 1'b0;
    logic [DW-1:0] bg_word = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, fail;
    logic [AW-1:0] fail_addr;
    logic [1:0]    fail_elem;

    always #10 clk = ~clk;

    march_bist #(.ADDR_W(AW), .DATA_W(DW)) u_march_bist (.*);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Fault model: two stuck-bit slots applied on the write path
    logic          f_on  [2];
    int            f_adr [2];
    int            f_bit [2];
    logic          f_val [2];
    logic [DW-1:0] ram [N];

    function automatic logic [DW-1:0] inject(input int a, input logic [DW-1:0] d);
        logic [DW-1:0] r = d;
        for (int s = 0; s < 2; s++)
            if (f_on[s] && f_adr[s] == a) r[f_bit[s]] = f_val[s];
        return r;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= inject(int'(mem_addr), mem_wdata);
            else        mem_rdata     <= ram[mem_addr];
        end
    end

    // Expected operation stream
    logic          exp_we   [MAXOPS];
    int            exp_adr  [MAXOPS];
    logic [DW-1:0] exp_dat  [MAXOPS];
    int            nexp, op_idx, err, last_issue;
    logic          mon_on = 1'b0;

    task automatic push(input logic we, input int a, input logic [DW-1:0] d);
        exp_we[nexp] = we; exp_adr[nexp] = a; exp_dat[nexp] = d; nexp++;
    endtask

    task automatic build_stream(input logic a, input logic [DW-1:0] bg);
        nexp = 0;
        for (int k = 0; k < N; k++) push(1'b1, k, bg);
        for (int k = 0; k < N; k++) begin push(1'b0, k, bg); push(1'b1, k, ~bg); end
        for (int k = N - 1; k >= 0; k--) begin
            push(1'b0, k, ~bg); push(1'b1, k, bg);
            if (!a) push(1'b0, k, bg);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && mem_en) begin
            if (op_idx >= nexp) err++;
            else if (mem_we !== exp_we[op_idx] || int'(mem_addr) != exp_adr[op_idx] ||
                     (mem_we && mem_wdata !== exp_dat[op_idx])) err++;
            op_idx++;
            last_issue = cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic run_case(input logic a, input logic [DW-1:0] bg, input bit mid_start,
                            input bit exp_fail, input int exp_a, input int exp_e);
        int done_cyc = -1;
        build_stream(a, bg);
        op_idx = 0; err = 0; mon_on = 1'b1;
        @(posedge clk); #1;
        start = 1'b1; alg_sel = a; bg_word = bg;
        @(posedge clk); #1;
        start = 1'b0; alg_sel = ~a; bg_word = ~bg;   // R1: must be ignored
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (mid_start && k == 20) start = 1'b1;   // R9: start while busy
            if (mid_start && k == 21) start = 1'b0;
            if (done) begin done_cyc = cyc; break; end
        end
        check(done_cyc >= 0, "R8 done seen", done_cyc, 0);
        check(fail === exp_fail, "R7 fail flag", int'(fail), int'(exp_fail));
        if (exp_fail) begin
            check(int'(fail_addr) == exp_a, "R7 fail_addr", int'(fail_addr), exp_a);
            check(int'(fail_elem) == exp_e, "R6 fail_elem", int'(fail_elem), exp_e);
        end
        check(done_cyc == last_issue + 2, "R8 done timing", done_cyc, last_issue + 2);
        check(op_idx == (a ? 5 : 6) * N, "R2 op count", op_idx, (a ? 5 : 6) * N);
        check(err == 0, mid_start ? "R9 R3 R4 R5 op stream" : "R3 R4 R5 R1 op stream", err, 0);
        @(negedge clk);
        check(!done && !busy, "R8 done single pulse", int'(done), 0);
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        f_on[0] = 0; f_on[1] = 0;
        f_adr[0] = 0; f_adr[1] = 0; f_bit[0] = 0; f_bit[1] = 0;
        f_val[0] = 0; f_val[1] = 0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !fail && !mem_en, "R1 reset state", int'(busy), 0);

        // Clean runs, both programs, several backgrounds
        for (int i = 0; i < 6; i++) begin
            logic [DW-1:0] bgs [3] = '{8'h00, 8'hFF, 8'hA5};
            run_case(1'(i % 2), bgs[i / 2], 1'b0, 1'b0, 0, 0);
        end

        // Stuck bit sweep over every address
        for (int a = 0; a < N; a++) begin
            for (int v = 0; v < 2; v++) begin
                logic [DW-1:0] bg = a[1] ? 8'h5A : 8'h33;
                int b = (a + v) % DW;
                f_on[0] = 1; f_adr[0] = a; f_bit[0] = b; f_val[0] = 1'(v);
                run_case(1'(a % 2), bg, 1'b0, 1'b1, a, (bg[b] != 1'(v)) ? 1 : 2);
            end
        end

        // Two faults: first mismatch in time wins (R7)
        f_on[0] = 1; f_adr[0] = 9;  f_bit[0] = 2; f_val[0] = 1'b0; // bg bit2=1 -> elem1
        f_on[1] = 1; f_adr[1] = 3;  f_bit[1] = 5; f_val[1] = 1'b0; // bg bit5=0 -> elem2
        run_case(1'b0, 8'h0F, 1'b0, 1'b1, 9, 1);
        f_adr[0] = 12; f_adr[1] = 3; f_bit[1] = 1; f_val[1] = 1'b0; // both elem1
        run_case(1'b0, 8'h0F, 1'b0, 1'b1, 3, 1);
        f_adr[0] = 4;  f_bit[0] = 6; f_adr[1] = 11; f_bit[1] = 7;    // both elem2, descending
        run_case(1'b1, 8'h0F, 1'b0, 1'b1, 11, 2);

        // Fault-free run after failures clears record; start while busy ignored
        f_on[0] = 0; f_on[1] = 0;
        run_case(1'b0, 8'h3C, 1'b1, 1'b0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule